// File: doc/BRIEF.md
# Staggered Auxiliary Reset Sequencer

This block watches one external reset request and turns it into three auxiliary reset outputs for downstream logic. When the request is sampled high, all three outputs rise together on the next clock edge. They are then released one after another, each after its own fixed number of clock cycles counted from the first cycle in which the request was seen. The short reset is released first, the medium one next, and the long one last.

A single up-counter measures the elapsed cycles. Three equality comparators watch that counter at the three release points, and a five-state control FSM turns their hits into the output pattern. The FSM has one idle state, three holding states and a counter-clear state. Requests that arrive while a sequence is running are ignored. After the last output drops, the block clears its counter and re-arms only once the request input has been seen low. The request is assumed to be synchronous to the clock and normally lasts 4 cycles. With the default parameters the outputs last 30, 24 and 16 cycles, which at a 50 MHz clock is 600 ns, 480 ns and 320 ns.

Top module: `staged_reset_seq`

## Requirements
- R1: While the block reset `rst_n` is low, and after it is released, all three outputs are low until a request is seen. Asserting `rst_n` in the middle of a sequence drops all outputs at once.
- R2: When `req_i` is sampled high in idle, `rst_long_o`, `rst_mid_o` and `rst_short_o` all rise together right after that same clock edge.
- R3: `rst_short_o` stays high for exactly `LEN_SHORT` (default 16) cycles, counted from the request's first sampled cycle.
- R4: `rst_mid_o` stays high for exactly `LEN_MID` (default 24) cycles, counted from the same cycle.
- R5: `rst_long_o` stays high for exactly `LEN_LONG` (default 30) cycles, counted from the same cycle. The internal cycle counter never exceeds `LEN_LONG`.
- R6: Outputs are released in a fixed order, short first, then mid, then long. At any time `rst_short_o` high implies `rst_mid_o` high, and `rst_mid_o` high implies `rst_long_o` high.
- R7: A new request, or a still-held one, that arrives while a sequence is running has no effect on the length of any output.
- R8: After the long output drops, a request that is still held high does not start a new sequence. The block re-arms only after `req_i` has been sampled low.
- R9: A later request after re-arming produces a sequence identical to the first one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| req_i | input | 1 | External reset request, active high, synchronous to `clk` |
| rst_long_o | output | 1 | Auxiliary reset released after `LEN_LONG` cycles |
| rst_mid_o | output | 1 | Auxiliary reset released after `LEN_MID` cycles |
| rst_short_o | output | 1 | Auxiliary reset released after `LEN_SHORT` cycles |

## Verification
A wrong FSM state or counter value shows at the ports as an output that drops a cycle early or late, or as a break in the short-inside-mid-inside-long nesting. The first visible sign therefore appears at the release edge of the affected output, at most `LEN_LONG` cycles after the request. A wrong return path, such as skipping the clear state or re-arming on a held request, shows only after the long output drops: the outputs rise again within one cycle while the request is still high. Each scenario samples every output on every cycle of the sequence, so a timing error of a single cycle is detected.

// File: rtl/staged_reset_pkg.sv
package staged_reset_pkg;
  typedef enum logic [2:0] {
    SEQ_IDLE    = 3'd0,
    SEQ_ALL     = 3'd1,
    SEQ_MIDLONG = 3'd2,
    SEQ_LONG    = 3'd3,
    SEQ_CLEAR   = 3'd4
  } seq_state_e;

  // output pattern: bit 0 = long, bit 1 = mid, bit 2 = short
  function automatic logic [2:0] state_pattern(seq_state_e s);
    case (s)
      SEQ_ALL:     return 3'b111;
      SEQ_MIDLONG: return 3'b011;
      SEQ_LONG:    return 3'b001;
      default:     return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/seq_cycle_counter.sv
module seq_cycle_counter #(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned LIMIT = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_we = clr_i | start_i | en_i;
    if (clr_i)        cnt_d = '0;
    else if (start_i) cnt_d = WIDTH'(1);
    else              cnt_d = cnt_q + WIDTH'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R5: counter stays inside its range
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIDTH'(LIMIT));
endmodule

// File: rtl/seq_count_match.sv
module seq_count_match #(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned VALUE = 16
) (
  input  logic [WIDTH-1:0] cnt_i,
  output logic             hit_o
);
  assign hit_o = (cnt_i == WIDTH'(VALUE));
endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import staged_reset_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic [2:0] hit_i,     // 0 = long, 1 = mid, 2 = short
  output logic       cnt_clr_o,
  output logic       cnt_start_o,
  output logic       cnt_en_o,
  output logic [2:0] aux_o      // 0 = long, 1 = mid, 2 = short
);
  seq_state_e state_q, state_d;
  logic [2:0] aux_q;

  always_comb begin
    state_d     = state_q;
    cnt_clr_o   = 1'b0;
    cnt_start_o = 1'b0;
    cnt_en_o    = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (req_i) begin
          state_d     = SEQ_ALL;
          cnt_start_o = 1'b1;
        end
      end
      SEQ_ALL: begin
        cnt_en_o = 1'b1;
        if (hit_i[2]) state_d = SEQ_MIDLONG;
      end
      SEQ_MIDLONG: begin
        cnt_en_o = 1'b1;
        if (hit_i[1]) state_d = SEQ_LONG;
      end
      SEQ_LONG: begin
        cnt_en_o = ~hit_i[0];
        if (hit_i[0]) state_d = SEQ_CLEAR;
      end
      SEQ_CLEAR: begin
        cnt_clr_o = 1'b1;
        if (!req_i) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      aux_q   <= 3'b000;
    end else begin
      state_q <= state_d;
      aux_q   <= state_pattern(state_d);
    end
  end

  assign aux_o = aux_q;

  // R8: the clear state is left only with the request low
  assert_rearm_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CLEAR && req_i) |=> (state_q == SEQ_CLEAR));
  // R7: a running sequence never goes back to idle directly
  assert_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {SEQ_ALL, SEQ_MIDLONG, SEQ_LONG}) |=> (state_q != SEQ_IDLE));
endmodule

// File: rtl/staged_reset_seq.sv
module staged_reset_seq #(
  parameter int unsigned LEN_LONG  = 30,
  parameter int unsigned LEN_MID   = 24,
  parameter int unsigned LEN_SHORT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic rst_long_o,
  output logic rst_mid_o,
  output logic rst_short_o
);
  localparam int unsigned CNT_W = $clog2(LEN_LONG + 1);
  localparam int unsigned LENS [3] = '{LEN_LONG, LEN_MID, LEN_SHORT};

  logic [CNT_W-1:0] cnt;
  logic [2:0]       hit;
  logic [2:0]       aux;
  logic             cnt_clr, cnt_start, cnt_en;

  seq_cycle_counter #(.WIDTH(CNT_W), .LIMIT(LEN_LONG)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .start_i(cnt_start),
    .en_i(cnt_en), .cnt_o(cnt)
  );

  for (genvar g = 0; g < 3; g++) begin : g_match
    seq_count_match #(.WIDTH(CNT_W), .VALUE(LENS[g])) u_match (
      .cnt_i(cnt), .hit_o(hit[g])
    );
  end

  seq_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .hit_i(hit),
    .cnt_clr_o(cnt_clr), .cnt_start_o(cnt_start), .cnt_en_o(cnt_en),
    .aux_o(aux)
  );

  assign rst_long_o  = aux[0];
  assign rst_mid_o   = aux[1];
  assign rst_short_o = aux[2];

  // R2: the three outputs rise on the same edge, right after a request
  assert_rise_together_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_long_o) |-> (rst_mid_o && rst_short_o && $past(req_i)));
  // R6: nesting of the three outputs
  assert_nesting_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_short_o || rst_mid_o) && (!rst_mid_o || rst_long_o));
  // R3: short output drops when the counter showed its length
  assert_short_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_short_o) |-> ($past(cnt) == CNT_W'(LEN_SHORT)));
  // R4: mid output drops at its length
  assert_mid_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_mid_o) |-> ($past(cnt) == CNT_W'(LEN_MID)));
  // R5: long output drops at its length
  assert_long_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_long_o) |-> ($past(cnt) == CNT_W'(LEN_LONG)));
endmodule

// File: tb/staged_reset_seq_tb.sv
module staged_reset_seq_tb_top;
  localparam time CLK_PERIOD = 20ns;
  localparam int  L_LONG  = 30;
  localparam int  L_MID   = 24;
  localparam int  L_SHORT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic o_long, o_mid, o_short;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  staged_reset_seq #(.LEN_LONG(L_LONG), .LEN_MID(L_MID), .LEN_SHORT(L_SHORT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .rst_long_o(o_long), .rst_mid_o(o_mid), .rst_short_o(o_short)
  );

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  // Run one sequence: request high at k=0..3 plus [s2,e2), sample k=1..n
  task automatic run_seq(input string tag, input int s2, input int e2, input int n);
    int bad_l = 0, bad_m = 0, bad_s = 0, hi_l = 0, hi_m = 0, hi_s = 0;
    bit first_ok = 1'b0;
    req = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k == 1) first_ok = o_long && o_mid && o_short;
      if (o_long  != (k <= L_LONG))  bad_l++;
      if (o_mid   != (k <= L_MID))   bad_m++;
      if (o_short != (k <= L_SHORT)) bad_s++;
      hi_l += int'(o_long); hi_m += int'(o_mid); hi_s += int'(o_short);
      req = (k < 4) || (k >= s2 && k < e2);
    end
    check(first_ok, "R2", {tag, " all rise together"}, int'(first_ok), 1);
    check(bad_s == 0 && hi_s == L_SHORT, "R3", {tag, " short length"}, hi_s, L_SHORT);
    check(bad_m == 0 && hi_m == L_MID,   "R4", {tag, " mid length"},   hi_m, L_MID);
    check(bad_l == 0 && hi_l == L_LONG,  "R5", {tag, " long length"},  hi_l, L_LONG);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(!o_long && !o_mid && !o_short, "R1", "outputs low in reset",
          {o_long, o_mid, o_short}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!o_long && !o_mid && !o_short, "R1", "outputs low after release",
          {o_long, o_mid, o_short}, 0);
  endtask

  task automatic t_basic;
    run_seq("R9 run1", 0, 0, 40);
    repeat (2) @(negedge clk);
    run_seq("R9 run2", 0, 0, 40);
  endtask

  task automatic t_retrigger;
    // R7: second request in the middle of the sequence
    run_seq("R7 retrigger", 10, 14, 40);
    check(!o_long, "R7", "idle after retrigger run", int'(o_long), 0);
  endtask

  task automatic t_held;
    int rise = 0;
    // R8: request held far past the end of the sequence
    run_seq("R8 held", 4, 50, 34);
    for (int k = 35; k < 50; k++) begin
      @(negedge clk);
      rise += int'(o_long | o_mid | o_short);
    end
    req = 1'b0;
    check(rise == 0, "R8", "no restart while held", rise, 0);
    @(negedge clk); @(negedge clk);
    run_seq("R8 after rearm", 0, 0, 40);
  endtask

  task automatic t_async_reset;
    req = 1'b1;
    repeat (4) @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    check(o_long && o_mid && o_short, "R2", "outputs high mid-sequence",
          {o_long, o_mid, o_short}, 7);
    rst_n = 1'b0;
    #1;
    check(!o_long && !o_mid && !o_short, "R1", "async drop mid-sequence",
          {o_long, o_mid, o_short}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    run_seq("R1 after reset", 0, 0, 40);
    // R6 nesting at rest
    check(!o_short && !o_mid && !o_long, "R6", "all released at end",
          {o_long, o_mid, o_short}, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_retrigger();
    t_held();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule